// File: doc/BRIEF.md
# Staged Multi-Cycle Processor Core

This block is a compact processor core. It runs one instruction at a time through a fixed chain of six steps: fetch, decode, execute, memory, write-back and PC update. Every instruction takes exactly six clock cycles, and this holds even when some steps have no work to do. The core holds eight 32-bit general registers, a program counter and three condition flags. One byte-addressed memory holds both the program and its data.

A host fills the memory through a byte-wide load port while reset is held. It then releases reset, and execution starts at address 0. The host watches the program counter port and the halted flag. After the core stops, the host reads the memory back through the same load port.

Top module: `seqcore_top`

## Requirements
- R1: While `rst` is high and at the first sample after it falls, `pc_dbg` is 0 and `halted` is 0. All registers reset to 0. The flags reset to zero=1, sign=0, overflow=0.
- R2: An instruction's first byte holds the operation code in bits 7:4 and a function code in bits 3:0. Operations with registers carry a second byte, with source register rA in bits 7:4 and rB in bits 3:0. Operations with a constant carry a 4-byte little-endian word after that, and the address of the following instruction counts these bytes. `pc_dbg` changes only on the sixth clock edge of each instruction.
- R3: Code 0 is a one-byte no-op. Code 2 copies rA into rB. Code 3 writes the constant into rB and takes 6 bytes. A register number of 8 or above reads as 0 and discards writes.
- R4: Code 6 (2 bytes) computes rB op rA and writes the result to rB. Function 0 is add, 1 is rB−rA, 2 is AND and 3 is XOR. It sets zero, sign and signed overflow, where overflow is always 0 for AND and XOR. No other operation changes the flags.
- R5: Code 4 stores rA as a little-endian word at rB+constant. Code 5 loads the word at rB+constant into rA. Both take 6 bytes, addresses wrap modulo the memory size, and both reach the same memory that holds the code.
- R6: Code 0xA (2 bytes) lowers register 4 by 4 and stores the old value of rA at the new address.
- R7: Code 0xB (2 bytes) reads the word at register 4, raises register 4 by 4 and writes the word into rA. When rA is 4, the loaded word is what register 4 keeps.
- R8: Code 7 (5 bytes) is a jump whose constant follows the first byte. It moves to the constant when its condition holds, and to the following instruction otherwise. The conditions by function code are: 0 always, 1 (sign≠overflow) or zero, 2 sign≠overflow, 3 zero, 4 not zero, 5 sign=overflow, 6 sign=overflow and not zero.
- R9: Code 1 stops the core. `halted` rises one cycle after that instruction starts. It stays high until reset, and `pc_dbg` stays at the stopping instruction's address.
- R10: Operation codes 8, 9 and 0xC–0xF are invalid. So are code 6 with a function above 3 and code 7 with a function above 6. An invalid instruction stops the core in the same way as code 1.
- R11: While `ld_en` is high, `ld_wdata` is written at `ld_addr` on the clock edge and has priority over the core's writes. `ld_rdata` always shows the byte stored at `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load-port byte write strobe |
| ld_addr | input | log2(MEM_BYTES) | Load-port byte address |
| ld_wdata | input | 8 | Load-port write byte |
| ld_rdata | output | 8 | Byte stored at `ld_addr` |
| halted | output | 1 | Core has stopped on halt or an invalid instruction |
| pc_dbg | output | 32 | Current program counter |

## Verification
The core runs five programs, and a behavioural instruction model checks the program counter and halted flag on every clock. After each program stops, the bench compares the whole memory image with the model's. The arithmetic program mixes all four operations, an overflowing add, and word accesses that are unaligned or use a negative offset. The stack program moves data through push and pop, and it covers a pop into the stack pointer, which shows whether the loaded word or the raised pointer wins. A jump matrix runs all seven conditions after less, equal, greater and overflowed-less compares, which separates signed from unsigned flag handling. Two short programs end on invalid encodings to show that the stopping address and the sticky flag are right.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 8;
    localparam int IDW    = 4;
    localparam int FETCH_BYTES = 6;

    localparam logic [3:0] IC_NOP   = 4'h0;
    localparam logic [3:0] IC_HALT  = 4'h1;
    localparam logic [3:0] IC_RRMOV = 4'h2;
    localparam logic [3:0] IC_IRMOV = 4'h3;
    localparam logic [3:0] IC_RMMOV = 4'h4;
    localparam logic [3:0] IC_MRMOV = 4'h5;
    localparam logic [3:0] IC_ALU   = 4'h6;
    localparam logic [3:0] IC_JUMP  = 4'h7;
    localparam logic [3:0] IC_PUSH  = 4'hA;
    localparam logic [3:0] IC_POP   = 4'hB;

    localparam logic [IDW-1:0] REG_SP   = 4'h4;
    localparam logic [IDW-1:0] REG_NONE = 4'hF;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXECUTE, ST_MEMORY, ST_WRBACK, ST_PCUPD, ST_HALT
    } stage_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_XOR
    } alu_op_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

endpackage

// File: rtl/seqcore_mem.sv
module seqcore_mem
    import seqcore_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int WB = XLEN / 8
) (
    input  logic                     clk,
    input  logic                     ld_en,
    input  logic [AW-1:0]            ld_addr,
    input  logic [7:0]               ld_wdata,
    output logic [7:0]               ld_rdata,
    input  logic [AW-1:0]            fetch_addr,
    output logic [8*FETCH_BYTES-1:0] fetch_win,
    input  logic [AW-1:0]            d_addr,
    input  logic                     d_we,
    input  logic [XLEN-1:0]          d_wdata,
    output logic [XLEN-1:0]          d_rdata
);

    logic [7:0] mem_q [MEM_BYTES];

    assign ld_rdata = mem_q[ld_addr];

    // Instruction window: consecutive bytes from the PC, wrapping.
    for (genvar g = 0; g < FETCH_BYTES; g++) begin : g_fetch
        assign fetch_win[8*g +: 8] = mem_q[fetch_addr + AW'(g)];
    end

    // Little-endian data word.
    for (genvar g = 0; g < WB; g++) begin : g_dread
        assign d_rdata[8*g +: 8] = mem_q[d_addr + AW'(g)];
    end

    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem_q[ld_addr] <= ld_wdata;
        end else if (d_we) begin
            for (int b = 0; b < WB; b++) begin
                mem_q[d_addr + AW'(b)] <= d_wdata[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/seqcore_regfile.sv
module seqcore_regfile
    import seqcore_pkg::*;
#(
    localparam int IW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDW-1:0]  rd_a_id,
    output logic [XLEN-1:0] rd_a_val,
    input  logic [IDW-1:0]  rd_b_id,
    output logic [XLEN-1:0] rd_b_val,
    input  logic            we_e,
    input  logic [IDW-1:0]  dst_e,
    input  logic [XLEN-1:0] val_e,
    input  logic            we_m,
    input  logic [IDW-1:0]  dst_m,
    input  logic [XLEN-1:0] val_m
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    assign rd_a_val = (rd_a_id < IDW'(NREGS)) ? regs_q[rd_a_id[IW-1:0]] : '0;
    assign rd_b_val = (rd_b_id < IDW'(NREGS)) ? regs_q[rd_b_id[IW-1:0]] : '0;

    // The memory-side port is applied last so it wins on a shared target.
    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
            if (we_e && dst_e == IDW'(i)) regs_d[i] = val_e;
            if (we_m && dst_m == IDW'(i)) regs_d[i] = val_m;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    AST_MPORT_WINS: assert property (@(posedge clk) disable iff (rst)
        (we_e && we_m && dst_e == dst_m && dst_m < IDW'(NREGS))
        |=> regs_q[$past(dst_m[IW-1:0])] == $past(val_m)); // R7

endmodule

// File: rtl/seqcore_alu.sv
module seqcore_alu
    import seqcore_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output flags_t          flags
);

    localparam int MSB = XLEN - 1;

    always_comb begin
        flags.of = 1'b0;
        case (op)
            ALU_ADD: begin
                res = opb + opa;
                flags.of = (opa[MSB] == opb[MSB]) && (res[MSB] != opb[MSB]);
            end
            ALU_SUB: begin
                res = opb - opa;
                flags.of = (opa[MSB] != opb[MSB]) && (res[MSB] != opb[MSB]);
            end
            ALU_AND: res = opb & opa;
            default: res = opb ^ opa;
        endcase
        flags.zf = (res == '0);
        flags.sf = res[MSB];
    end

endmodule

// File: rtl/seqcore_cond.sv
module seqcore_cond
    import seqcore_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] fn,
    output logic       take
);

    logic lt;

    assign lt = flags.sf ^ flags.of;

    always_comb begin
        case (fn)
            4'd0:    take = 1'b1;
            4'd1:    take = lt | flags.zf;
            4'd2:    take = lt;
            4'd3:    take = flags.zf;
            4'd4:    take = ~flags.zf;
            4'd5:    take = ~lt;
            4'd6:    take = ~lt & ~flags.zf;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/seqcore_top.sv
module seqcore_top
    import seqcore_pkg::*;
#(
    parameter int MEM_BYTES = 512,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_addr,
    input  logic [7:0]      ld_wdata,
    output logic [7:0]      ld_rdata,
    output logic            halted,
    output logic [XLEN-1:0] pc_dbg
);

    typedef struct packed {
        stage_e          stage;
        logic [XLEN-1:0] pc;
        logic [3:0]      icode;
        logic [3:0]      ifun;
        logic [IDW-1:0]  ra;
        logic [IDW-1:0]  rb;
        logic [XLEN-1:0] valc;
        logic [XLEN-1:0] valp;
        logic [XLEN-1:0] vala;
        logic [XLEN-1:0] valb;
        logic [XLEN-1:0] vale;
        logic [XLEN-1:0] valm;
        logic            cnd;
        flags_t          cc;
    } core_t;

    core_t core_q, core_d;

    // Fetch-side decode of the instruction window
    logic [8*FETCH_BYTES-1:0] fetch_win;
    logic [3:0]      f_icode, f_ifun;
    logic            f_has_regs, f_has_const, f_valid;
    logic [XLEN-1:0] f_valc, f_valp;

    // Datapath wires between the pieces
    logic [IDW-1:0]  src_a, src_b;
    logic [XLEN-1:0] rf_a_val, rf_b_val;
    logic            we_e, we_m;
    logic [IDW-1:0]  dst_e, dst_m;
    logic [XLEN-1:0] alu_a, alu_b, alu_res;
    alu_op_e         alu_op;
    flags_t          alu_flags;
    logic            jump_take;
    logic [XLEN-1:0] mem_addr_full, d_rdata;
    logic            d_we, d_rd;

    assign f_icode = fetch_win[7:4];
    assign f_ifun  = fetch_win[3:0];

    always_comb begin
        f_has_regs  = 1'b0;
        f_has_const = 1'b0;
        f_valid     = 1'b1;
        case (f_icode)
            IC_NOP, IC_HALT: ;
            IC_RRMOV, IC_PUSH, IC_POP: f_has_regs = 1'b1;
            IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
                f_has_regs  = 1'b1;
                f_has_const = 1'b1;
            end
            IC_ALU: begin
                f_has_regs = 1'b1;
                f_valid    = (f_ifun <= 4'd3);
            end
            IC_JUMP: begin
                f_has_const = 1'b1;
                f_valid     = (f_ifun <= 4'd6);
            end
            default: f_valid = 1'b0;
        endcase
    end

    assign f_valc = f_has_regs ? fetch_win[47:16] : fetch_win[39:8];
    assign f_valp = core_q.pc + XLEN'(1)
                  + (f_has_regs  ? XLEN'(1) : '0)
                  + (f_has_const ? XLEN'(4) : '0);

    // Register-file source selection (used in the decode step)
    always_comb begin
        src_a = REG_NONE;
        src_b = REG_NONE;
        case (core_q.icode)
            IC_RRMOV, IC_RMMOV, IC_ALU, IC_PUSH: src_a = core_q.ra;
            IC_POP:                              src_a = REG_SP;
            default: ;
        endcase
        case (core_q.icode)
            IC_ALU, IC_RMMOV, IC_MRMOV: src_b = core_q.rb;
            IC_PUSH, IC_POP:            src_b = REG_SP;
            default: ;
        endcase
    end

    // ALU operand selection (used in the execute step)
    always_comb begin
        alu_a  = '0;
        alu_b  = '0;
        alu_op = ALU_ADD;
        case (core_q.icode)
            IC_RRMOV: alu_a = core_q.vala;
            IC_IRMOV: alu_a = core_q.valc;
            IC_RMMOV, IC_MRMOV: begin
                alu_a = core_q.valc;
                alu_b = core_q.valb;
            end
            IC_ALU: begin
                alu_a  = core_q.vala;
                alu_b  = core_q.valb;
                alu_op = alu_op_e'(core_q.ifun[1:0]);
            end
            IC_PUSH: begin
                alu_a = ~XLEN'(3);
                alu_b = core_q.valb;
            end
            IC_POP: begin
                alu_a = XLEN'(4);
                alu_b = core_q.valb;
            end
            default: ;
        endcase
    end

    // Memory step controls
    assign mem_addr_full = (core_q.icode == IC_POP) ? core_q.vala : core_q.vale;
    assign d_we = (core_q.stage == ST_MEMORY)
               && (core_q.icode == IC_RMMOV || core_q.icode == IC_PUSH);
    assign d_rd = (core_q.icode == IC_MRMOV || core_q.icode == IC_POP);

    // Write-back controls
    always_comb begin
        we_e  = 1'b0;
        we_m  = 1'b0;
        dst_e = core_q.rb;
        dst_m = core_q.ra;
        if (core_q.stage == ST_WRBACK) begin
            case (core_q.icode)
                IC_RRMOV, IC_IRMOV, IC_ALU: we_e = 1'b1;
                IC_PUSH: begin
                    we_e  = 1'b1;
                    dst_e = REG_SP;
                end
                IC_POP: begin
                    we_e  = 1'b1;
                    dst_e = REG_SP;
                    we_m  = 1'b1;
                end
                IC_MRMOV: we_m = 1'b1;
                default: ;
            endcase
        end
    end

    // Next-state computation for the step sequencer
    always_comb begin
        core_d = core_q;
        case (core_q.stage)
            ST_FETCH: begin
                if (!f_valid || f_icode == IC_HALT) begin
                    core_d.stage = ST_HALT;
                end else begin
                    core_d.icode = f_icode;
                    core_d.ifun  = f_ifun;
                    core_d.ra    = f_has_regs ? fetch_win[15:12] : REG_NONE;
                    core_d.rb    = f_has_regs ? fetch_win[11:8]  : REG_NONE;
                    core_d.valc  = f_valc;
                    core_d.valp  = f_valp;
                    core_d.stage = ST_DECODE;
                end
            end
            ST_DECODE: begin
                core_d.vala  = rf_a_val;
                core_d.valb  = rf_b_val;
                core_d.stage = ST_EXECUTE;
            end
            ST_EXECUTE: begin
                core_d.vale = alu_res;
                core_d.cnd  = (core_q.icode == IC_JUMP) && jump_take;
                if (core_q.icode == IC_ALU) core_d.cc = alu_flags;
                core_d.stage = ST_MEMORY;
            end
            ST_MEMORY: begin
                if (d_rd) core_d.valm = d_rdata;
                core_d.stage = ST_WRBACK;
            end
            ST_WRBACK: core_d.stage = ST_PCUPD;
            ST_PCUPD: begin
                core_d.pc    = core_q.cnd ? core_q.valc : core_q.valp;
                core_d.stage = ST_FETCH;
            end
            default: core_d.stage = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q       <= '0;
            core_q.stage <= ST_FETCH;
            core_q.cc    <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign halted = (core_q.stage == ST_HALT);
    assign pc_dbg = core_q.pc;

    seqcore_mem #(.MEM_BYTES(MEM_BYTES)) i_mem (
        .clk        (clk),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_wdata   (ld_wdata),
        .ld_rdata   (ld_rdata),
        .fetch_addr (core_q.pc[AW-1:0]),
        .fetch_win  (fetch_win),
        .d_addr     (mem_addr_full[AW-1:0]),
        .d_we       (d_we),
        .d_wdata    (core_q.vala),
        .d_rdata    (d_rdata)
    );

    seqcore_regfile i_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_a_id  (src_a),
        .rd_a_val (rf_a_val),
        .rd_b_id  (src_b),
        .rd_b_val (rf_b_val),
        .we_e     (we_e),
        .dst_e    (dst_e),
        .val_e    (core_q.vale),
        .we_m     (we_m),
        .dst_m    (dst_m),
        .val_m    (core_q.valm)
    );

    seqcore_alu i_alu (
        .opa   (alu_a),
        .opb   (alu_b),
        .op    (alu_op),
        .res   (alu_res),
        .flags (alu_flags)
    );

    seqcore_cond i_cond (
        .flags (core_q.cc),
        .fn    (core_q.ifun),
        .take  (jump_take)
    );

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9

    AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_dbg)); // R9

    AST_PC_ONLY_AT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (core_q.stage != ST_PCUPD) |=> $stable(pc_dbg)); // R2

    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        (core_q.stage == ST_DECODE) |-> ($past(core_q.stage) == ST_FETCH)); // R2

    AST_FLAGS_ONLY_ALU: assert property (@(posedge clk) disable iff (rst)
        !(core_q.stage == ST_EXECUTE && core_q.icode == IC_ALU)
        |=> $stable(core_q.cc)); // R4

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(d_we && (we_e || we_m))); // R5

endmodule

// File: tb/test_seqcore_top.sv
module test_seqcore_top;

    localparam int MB = 512;
    localparam int AW = $clog2(MB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_wdata = '0;
    logic [7:0]    ld_rdata;
    logic          halted;
    logic [31:0]   pc_dbg;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seqcore_top #(.MEM_BYTES(MB)) i_seqcore_top (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(ld_rdata),
        .halted(halted), .pc_dbg(pc_dbg)
    );

    // Program image and behavioural model state
    logic [7:0]  img  [MB];
    logic [7:0]  rmem [MB];
    logic [31:0] rreg [8];
    logic        zf, sf, of;
    int          wp;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Tiny assembler
    task automatic eb(input logic [7:0] b);
        img[wp] = b;
        wp++;
    endtask
    task automatic ew(input logic [31:0] w);
        for (int k = 0; k < 4; k++) eb(w[8*k +: 8]);
    endtask
    task automatic a_nop();                        eb(8'h00); endtask
    task automatic a_halt();                       eb(8'h10); endtask
    task automatic a_rr(input int ra, input int rb);  eb(8'h20); eb({4'(ra), 4'(rb)}); endtask
    task automatic a_ir(input logic [31:0] v, input int rb); eb(8'h30); eb({4'hF, 4'(rb)}); ew(v); endtask
    task automatic a_rm(input int ra, input logic [31:0] d, input int rb); eb(8'h40); eb({4'(ra), 4'(rb)}); ew(d); endtask
    task automatic a_mr(input logic [31:0] d, input int rb, input int ra); eb(8'h50); eb({4'(ra), 4'(rb)}); ew(d); endtask
    task automatic a_op(input int fn, input int ra, input int rb); eb({4'h6, 4'(fn)}); eb({4'(ra), 4'(rb)}); endtask
    task automatic a_j(input int fn, input logic [31:0] dest); eb({4'h7, 4'(fn)}); ew(dest); endtask
    task automatic a_push(input int ra);           eb(8'hA0); eb({4'(ra), 4'hF}); endtask
    task automatic a_pop(input int ra);            eb(8'hB0); eb({4'(ra), 4'hF}); endtask

    task automatic clear_img();
        for (int i = 0; i < MB; i++) img[i] = 8'h00;
        wp = 0;
    endtask

    // Model helpers
    function automatic logic [31:0] rd(input logic [3:0] id);
        return (id < 8) ? rreg[id[2:0]] : 32'h0;
    endfunction
    task automatic wr(input logic [3:0] id, input logic [31:0] v);
        if (id < 8) rreg[id[2:0]] = v;
    endtask
    function automatic logic [31:0] mrd(input logic [31:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = rmem[(a + k) & (MB - 1)];
        return w;
    endfunction
    task automatic mwr(input logic [31:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) rmem[(a + k) & (MB - 1)] = v[8*k +: 8];
    endtask

    // Execute one instruction in the model
    task automatic ref_step(input logic [31:0] pc, output bit stop, output bit bad,
                            output logic [31:0] npc);
        logic [7:0]  b0, b1;
        logic [3:0]  ic, fn, ra, rb;
        logic [31:0] c, a, b, r, sp, v;
        bit          take, lt;
        b0 = rmem[pc & (MB - 1)];
        b1 = rmem[(pc + 1) & (MB - 1)];
        ic = b0[7:4]; fn = b0[3:0]; ra = b1[7:4]; rb = b1[3:0];
        stop = 0; bad = 0; npc = pc;
        bad = !(ic inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'hA, 4'hB}
                || (ic == 4'h6 && fn <= 3) || (ic == 4'h7 && fn <= 6));
        if (bad || ic == 4'h1) begin
            stop = 1;
            return;
        end
        case (ic)
            4'h0: npc = pc + 1;
            4'h2: begin wr(rb, rd(ra)); npc = pc + 2; end
            4'h3: begin wr(rb, mrd(pc + 2)); npc = pc + 6; end
            4'h4: begin mwr(rd(rb) + mrd(pc + 2), rd(ra)); npc = pc + 6; end
            4'h5: begin wr(ra, mrd(rd(rb) + mrd(pc + 2))); npc = pc + 6; end
            4'h6: begin
                a = rd(ra); b = rd(rb); of = 0;
                case (fn)
                    4'd0: begin r = b + a; of = (a[31] == b[31]) && (r[31] != b[31]); end
                    4'd1: begin r = b - a; of = (a[31] != b[31]) && (r[31] != b[31]); end
                    4'd2: r = b & a;
                    default: r = b ^ a;
                endcase
                zf = (r == 0); sf = r[31];
                wr(rb, r);
                npc = pc + 2;
            end
            4'h7: begin
                c = mrd(pc + 1);
                lt = sf ^ of;
                case (fn)
                    4'd0: take = 1;
                    4'd1: take = lt || zf;
                    4'd2: take = lt;
                    4'd3: take = zf;
                    4'd4: take = !zf;
                    4'd5: take = !lt;
                    default: take = !lt && !zf;
                endcase
                npc = take ? c : pc + 5;
            end
            4'hA: begin
                v = rd(ra); sp = rreg[4] - 4;
                mwr(sp, v); rreg[4] = sp;
                npc = pc + 2;
            end
            default: begin
                sp = rreg[4]; v = mrd(sp);
                rreg[4] = sp + 4;
                wr(ra, v);
                npc = pc + 2;
            end
        endcase
    endtask

    // Load, run cycle by cycle against the model, then compare memory
    task automatic run_prog(input string tag);
        logic [31:0] mpc, npc;
        bit stop, bad, done;
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < MB; i++) begin
            ld_en = 1'b1; ld_addr = AW'(i); ld_wdata = img[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        for (int i = 0; i < MB; i++) rmem[i] = img[i];
        for (int i = 0; i < 8; i++) rreg[i] = 32'h0;
        zf = 1; sf = 0; of = 0;
        check(pc_dbg == 0, "R1", "pc in reset", pc_dbg, 0);
        check(halted == 0, "R1", "halted in reset", {31'h0, halted}, 0);
        rst = 1'b0;
        #1;
        check(pc_dbg == 0 && halted == 0, "R1", "state after reset release",
              pc_dbg, 0);
        mpc = 0;
        done = 0;
        for (int n = 0; n < 400 && !done; n++) begin
            ref_step(mpc, stop, bad, npc);
            if (stop) begin
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    check(halted == 1, bad ? "R10" : "R9", "halted flag",
                          {31'h0, halted}, 1);
                    check(pc_dbg == mpc, bad ? "R10" : "R9", "pc at stop",
                          pc_dbg, mpc);
                end
                done = 1;
            end else begin
                for (int k = 1; k <= 6; k++) begin
                    @(negedge clk);
                    check(pc_dbg == ((k == 6) ? npc : mpc), "R2",
                          $sformatf("%s pc step %0d", tag, k), pc_dbg,
                          (k == 6) ? npc : mpc);
                    check(halted == 0, "R2", "running", {31'h0, halted}, 0);
                end
                mpc = npc;
            end
        end
        check(done, "R9", {tag, " program stopped"}, {31'h0, done}, 1);
        for (int i = 0; i < MB; i++) begin
            ld_addr = AW'(i);
            #1;
            check(ld_rdata == rmem[i], tag, $sformatf("mem[%0h]", i),
                  {24'h0, ld_rdata}, {24'h0, rmem[i]});
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Program 1: data moves, all ALU functions, overflow, word access (R3 R4 R5)
        clear_img();
        a_ir(32'h12345678, 0);
        a_ir(32'h0F0F0F0F, 1);
        a_nop();
        a_rr(0, 2); a_op(0, 1, 2); a_rm(2, 32'h100, 15);
        a_rr(0, 3); a_op(1, 1, 3); a_rm(3, 32'h104, 15);
        a_rr(0, 5); a_op(2, 1, 5); a_rm(5, 32'h108, 15);
        a_rr(0, 6); a_op(3, 1, 6); a_rm(6, 32'h10C, 15);
        a_ir(32'h7FFFFFFF, 2); a_ir(32'h1, 3); a_op(0, 3, 2); a_rm(2, 32'h110, 15);
        a_ir(32'h110, 7); a_mr(32'hFFFFFFF0, 7, 3); a_rm(3, 32'h8, 7);
        a_rm(0, 32'h121, 15);
        a_rr(0, 15);
        a_halt();
        run_prog("R4");

        // Program 2: stack push/pop, pop into the stack pointer (R6 R7)
        clear_img();
        a_ir(32'h1F0, 4);
        a_ir(32'hAABBCCDD, 0); a_push(0);
        a_ir(32'h11, 0); a_push(0);
        a_pop(1); a_pop(2);
        a_rm(1, 32'h100, 15); a_rm(2, 32'h104, 15); a_rm(4, 32'h108, 15);
        a_push(4); a_pop(5); a_rm(5, 32'h10C, 15);
        a_ir(32'h55, 3); a_push(3); a_pop(4);
        a_rm(4, 32'h110, 15);
        a_halt();
        run_prog("R7");

        // Program 3: every jump condition after four compare outcomes (R8)
        clear_img();
        a_ir(32'h1, 7);
        for (int c = 0; c < 4; c++) begin
            logic [31:0] av, bv;
            case (c)
                0: begin av = 5; bv = 3; end
                1: begin av = 7; bv = 7; end
                2: begin av = 2; bv = 9; end
                default: begin av = 1; bv = 32'h80000000; end
            endcase
            a_ir(av, 0); a_ir(bv, 1); a_op(1, 0, 1);
            for (int f = 0; f < 7; f++) begin
                a_j(f, 32'(wp + 11));
                a_rm(7, 32'(400 + 4 * (c * 7 + f)), 15);
            end
        end
        a_halt();
        run_prog("R8");

        // Program 4: ALU code with an out-of-range function (R10)
        clear_img();
        a_nop(); a_ir(32'h44, 1); eb(8'h67); eb(8'h12);
        run_prog("R10");

        // Program 5: undefined operation code, load-port priority (R10 R11)
        clear_img();
        a_nop(); a_nop(); eb(8'h90);
        run_prog("R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule